// File: doc/BRIEF.md
# Packed-Operand Arithmetic Processing Element

This block takes one 64-bit word that holds two 32-bit operands in single-precision layout. Operand A sits in the upper half and operand B in the lower half. From one start pulse it forms a 42-bit packed product word. The top bit of that word is the XOR of the two operand signs. Below it is the modulo-256 sum of the two 8-bit exponent fields. The low 33 bits hold the zero-extended 32-bit product of the low 16 mantissa bits of each operand.

The product is built in sequence from four 8x8 partial products, one per cycle, and then combined by shift-and-add. In parallel, a divider works on the same two 16-bit mantissa fields, with A as the dividend and B as the divisor. It repeatedly adds the two's complement of the divisor and counts each step that stays non-negative.

When both paths have finished, all results are registered together and a one-cycle done pulse is raised. No rounding, special-value handling or exponent bias correction is done. The enable input freezes every sequencing register while it is low.

Top module: `packed_arith_pe`

## Requirements
- R1: After a completed operation, res_word[41] equals op_word[63] XOR op_word[31].
- R2: res_word[40:33] equals (op_word[62:55] + op_word[30:23]) mod 256; the carry out of this sum is discarded.
- R3: res_word[32:0] equals op_word[47:32] times op_word[15:0] as unsigned 16-bit integers, zero-extended, so res_word[32] is always 0.
- R4: For a nonzero divisor op_word[15:0], quot_out is the floor of op_word[47:32] / op_word[15:0], rem_out is the remainder, and div_zero is 0.
- R5: For a zero divisor, quot_out is 16'hFFFF, rem_out equals the dividend op_word[47:32], and div_zero is 1.
- R6: done is high for exactly one clock cycle per accepted start.
- R7: Counted in rising edges with the start edge as edge 0, done is first seen high after edge max(6, Q+2) when Q is the quotient. The latency is 6 for a zero divisor. done is never high in the cycle right after an accepted start.
- R8: res_word, quot_out, rem_out and div_zero change only on the edge that raises done. They hold their values until the next completed operation, even if op_word changes.
- R9: While en is low, no sequencing advances, done stays low and outputs hold. Raising en again resumes the operation, which then gives the correct results.
- R10: A start while en is low is not accepted: it produces no done and no output change.
- R11: After the synchronous active-high reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low freezes all sequencing |
| start | input | 1 | Begin an operation on op_word (sampled when en is high) |
| op_word | input | 64 | Packed operands: A in [63:32], B in [31:0] |
| res_word | output | 42 | {sign, exponent[7:0], mantissa[32:0]} |
| quot_out | output | 16 | Quotient of the mantissa fields |
| rem_out | output | 16 | Remainder of the mantissa fields |
| div_zero | output | 1 | Last divisor was zero |
| done | output | 1 | One-cycle pulse when results are updated |

## Verification
If a partial product lands in the wrong place, or the four steps run out of order, the mantissa bits of res_word are wrong on the very done pulse of that operation. A miscounting divider shows up in two ways: a wrong quotient or remainder, and a done that arrives earlier or later than max(6, Q+2) edges. A sequencing register that keeps running while en is low shows up the same way. In that case done fires during the freeze, or the outputs change before the operation is allowed to finish. Random operands, the directed corner cases (zero divisor, dividend below divisor, largest mantissas, exponent wrap) and latency counting therefore reveal such faults within one operation.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int OPND_W  = 32;
  localparam int EXP_W   = 8;
  localparam int MANT_W  = 16;
  localparam int MFLD_W  = 33;
  localparam int RES_W   = 1 + EXP_W + MFLD_W;
  localparam int WORD_W  = 2 * OPND_W;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_PART = 2'd1,
    MS_SUM  = 2'd2
  } mul_state_e;
endpackage

// File: rtl/pe_quad_mult.sv
module pe_quad_mult
  import pe_pkg::*;
#(
  parameter int MW = MANT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start,
  input  logic [MW-1:0] a_in,
  input  logic [MW-1:0] b_in,
  output logic [2*MW-1:0] mant,
  output logic          fin
);
  localparam int H  = MW / 2;
  localparam int PW = 2 * H;
  localparam int TW = 3 * H;

  mul_state_e   st;
  logic [MW-1:0] a_q, b_q;
  logic [1:0]    step;
  logic [PW-1:0] pp [4];
  logic [H-1:0]  opa, opb;

  // quadrant selection: step 0 lo*lo, 1 Ahi*Blo, 2 Alo*Bhi, 3 hi*hi
  always_comb begin
    opa = step[0] ? a_q[MW-1:H] : a_q[H-1:0];
    opb = step[1] ? b_q[MW-1:H] : b_q[H-1:0];
  end

  logic [TW-1:0]   t_lo, t_hi;
  logic [2*MW-1:0] m_sum;
  always_comb begin
    t_hi  = ({{H{1'b0}}, pp[3]} << H) + {{H{1'b0}}, pp[2]};
    t_lo  = ({{H{1'b0}}, pp[1]} << H) + {{H{1'b0}}, pp[0]};
    m_sum = ({{H{1'b0}}, t_hi} << H) + {{H{1'b0}}, t_lo};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= MS_IDLE;
      a_q  <= '0;
      b_q  <= '0;
      step <= '0;
      mant <= '0;
      fin  <= 1'b0;
      for (int i = 0; i < 4; i++) pp[i] <= '0;
    end else if (en) begin
      if (start) begin
        a_q  <= a_in;
        b_q  <= b_in;
        step <= '0;
        fin  <= 1'b0;
        st   <= MS_PART;
      end else begin
        case (st)
          MS_PART: begin
            pp[step] <= opa * opb;
            step     <= step + 2'd1;
            if (step == 2'd3) st <= MS_SUM;
          end
          MS_SUM: begin
            mant <= m_sum;
            fin  <= 1'b1;
            st   <= MS_IDLE;
          end
          default: st <= MS_IDLE;
        endcase
      end
    end
  end

  // R3: partial products are taken in strict sequence
  step_order_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !start && st == MS_PART) |=> (step == $past(step) + 2'd1));
endmodule

// File: rtl/pe_repsub_div.sv
module pe_repsub_div
  import pe_pkg::*;
#(
  parameter int W = MANT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         start,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         dz,
  output logic         fin
);
  logic [W-1:0] neg_q, dvs_q;
  logic         run;
  logic [W:0]   trial;
  logic         fits;

  always_comb begin
    trial = {1'b0, rem} + {1'b0, neg_q};
    fits  = trial[W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      neg_q <= '0;
      dvs_q <= '0;
      quot  <= '0;
      dz    <= 1'b0;
      run   <= 1'b0;
      fin   <= 1'b0;
    end else if (en) begin
      if (start) begin
        rem   <= dvd;
        dvs_q <= dvs;
        neg_q <= ~dvs + 1'b1;
        if (dvs == '0) begin
          quot <= '1;
          dz   <= 1'b1;
          run  <= 1'b0;
          fin  <= 1'b1;
        end else begin
          quot <= '0;
          dz   <= 1'b0;
          run  <= 1'b1;
          fin  <= 1'b0;
        end
      end else if (run) begin
        if (fits) begin
          rem  <= trial[W-1:0];
          quot <= quot + 1'b1;
        end else begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  // R4
  rem_below_div_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && !dz) |-> (rem < dvs_q));
endmodule

// File: rtl/packed_arith_pe.sv
module packed_arith_pe
  import pe_pkg::*;
#(
  parameter int OW = OPND_W,
  parameter int EW = EXP_W,
  parameter int MW = MANT_W,
  parameter int FW = MFLD_W,
  localparam int RW = 1 + EW + FW,
  localparam int IW = 2 * OW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start,
  input  logic [IW-1:0] op_word,
  output logic [RW-1:0] res_word,
  output logic [MW-1:0] quot_out,
  output logic [MW-1:0] rem_out,
  output logic          div_zero,
  output logic          done
);
  logic [OW-1:0] opa, opb;
  assign opa = op_word[IW-1:OW];
  assign opb = op_word[OW-1:0];

  logic          sgn_in;
  logic [EW-1:0] exp_in;
  assign sgn_in = opa[OW-1] ^ opb[OW-1];
  assign exp_in = opa[OW-2 -: EW] + opb[OW-2 -: EW];

  logic unused_mant_hi;
  assign unused_mant_hi = ^{opa[OW-2-EW:MW], opb[OW-2-EW:MW]};

  logic [2*MW-1:0] m_val;
  logic            m_fin;
  logic [MW-1:0]   d_q, d_r;
  logic            d_z, d_fin;

  pe_quad_mult #(.MW(MW)) mult_u (
    .clk(clk), .rst(rst), .en(en), .start(start),
    .a_in(opa[MW-1:0]), .b_in(opb[MW-1:0]),
    .mant(m_val), .fin(m_fin)
  );

  pe_repsub_div #(.W(MW)) div_u (
    .clk(clk), .rst(rst), .en(en), .start(start),
    .dvd(opa[MW-1:0]), .dvs(opb[MW-1:0]),
    .quot(d_q), .rem(d_r), .dz(d_z), .fin(d_fin)
  );

  logic          busy, sgn_q;
  logic [EW-1:0] exp_q;
  logic          fire;
  assign fire = busy && m_fin && d_fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sgn_q    <= 1'b0;
      exp_q    <= '0;
      res_word <= '0;
      quot_out <= '0;
      rem_out  <= '0;
      div_zero <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (en) begin
        if (start) begin
          busy  <= 1'b1;
          sgn_q <= sgn_in;
          exp_q <= exp_in;
        end else if (fire) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          res_word <= {sgn_q, exp_q, {(FW-2*MW){1'b0}}, m_val};
          quot_out <= d_q;
          rem_out  <= d_r;
          div_zero <= d_z;
        end
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res_word) && $stable(quot_out) && $stable(rem_out) && $stable(div_zero)));

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !done);

  // R7
  early_done_chk: assert property (@(posedge clk) disable iff (rst)
    (en && start) |=> !done);

  // R3
  mant_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_word[FW-1] == 1'b0));
endmodule

// File: tb/packed_arith_pe_tb.sv
module packed_arith_pe_tb_top;
  logic        clk = 1'b0;
  logic        rst, en, start;
  logic [63:0] op_word;
  logic [41:0] res_word;
  logic [15:0] quot_out, rem_out;
  logic        div_zero, done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  packed_arith_pe dut_i (
    .clk(clk), .rst(rst), .en(en), .start(start), .op_word(op_word),
    .res_word(res_word), .quot_out(quot_out), .rem_out(rem_out),
    .div_zero(div_zero), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <190000", cyc);
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [41:0] exp_res(input logic [63:0] w);
    logic [7:0]  e;
    logic [31:0] m;
    e = w[62:55] + w[30:23];
    m = w[47:32] * w[15:0];
    return {w[63] ^ w[31], e, 1'b0, m};
  endfunction

  function automatic int exp_lat(input logic [63:0] w);
    int q;
    if (w[15:0] == 16'd0) return 6;
    q = int'(w[47:32] / w[15:0]);
    return (q + 2 > 6) ? q + 2 : 6;
  endfunction

  task automatic wait_done(output int n);
    n = 0;
    for (int k = 0; k < 70000; k++) begin
      @(posedge clk); #1;
      n++;
      if (done) return;
    end
    n = -1;
  endtask

  task automatic run_op(input logic [63:0] w, input bit chk_lat);
    int n;
    logic [15:0] eq, er;
    @(negedge clk);
    op_word = w; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    check(n > 0, "R6 done seen", 64'(n), 64'd1);
    check(res_word[41] == (w[63] ^ w[31]), "R1 sign", 64'(res_word[41]), 64'(w[63] ^ w[31]));
    check(res_word[40:0] == exp_res(w)[40:0], "R2/R3 exponent+mantissa", 64'(res_word), 64'(exp_res(w)));
    if (w[15:0] == 16'd0) begin
      check(quot_out == 16'hFFFF && rem_out == w[47:32] && div_zero,
            "R5 zero divisor", {31'd0, div_zero, quot_out, rem_out}, {31'd0, 1'b1, 16'hFFFF, w[47:32]});
    end else begin
      eq = w[47:32] / w[15:0];
      er = w[47:32] % w[15:0];
      check(quot_out == eq && rem_out == er && !div_zero,
            "R4 quotient/remainder", {31'd0, div_zero, quot_out, rem_out}, {32'd0, eq, er});
    end
    if (chk_lat)
      check(n == exp_lat(w), "R7 latency", 64'(n), 64'(exp_lat(w)));
    @(posedge clk); #1;
    check(!done, "R6 single pulse", 64'(done), 64'd0);
  endtask

  initial begin
    logic [41:0] keep_r;
    logic [15:0] keep_q;
    logic [63:0] w;
    int n;
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; en = 1'b1; start = 1'b0; op_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check(res_word == '0 && quot_out == '0 && rem_out == '0 && !div_zero && !done,
          "R11 reset state", {6'd0, res_word, quot_out}, 64'd0);

    // directed corners
    run_op({1'b1, 8'h80, 7'h00, 16'h1234, 1'b0, 8'h05, 7'h00, 16'h0000}, 1'b1); // R5
    run_op({1'b0, 8'hFF, 7'h7F, 16'h0003, 1'b1, 8'h01, 7'h7F, 16'h0100}, 1'b1); // R2 wrap, q=0
    run_op({1'b1, 8'h10, 7'h00, 16'hFFFF, 1'b1, 8'h20, 7'h00, 16'hFFFF}, 1'b1); // R3 max, q=1
    run_op({32'h0000_0400, 32'h0000_0001}, 1'b1);                               // R7 long divide
    run_op({32'h0000_0000, 32'h8000_00FF}, 1'b1);                               // zero dividend

    // random
    for (int i = 0; i < 40; i++) begin
      w = {$urandom, $urandom};
      if (i % 4 != 3) w[15:0] = w[15:0] | 16'h0040;
      run_op(w, 1'b1);
    end

    // R8: outputs hold while op_word changes without start
    keep_r = res_word; keep_q = quot_out;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); op_word = {$urandom, $urandom};
    end
    #1;
    check(res_word == keep_r && quot_out == keep_q, "R8 hold", 64'(res_word), 64'(keep_r));

    // R10: start while en low is ignored
    @(negedge clk); en = 1'b0; start = 1'b1; op_word = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk); start = 1'b0; en = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (done) n++;
    end
    check(n == 0 && res_word == keep_r, "R10 ignored start", 64'(n), 64'd0);

    // R9: freeze mid-operation
    w = {32'h0000_2000, 32'h0000_0010};
    @(negedge clk); op_word = w; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b0;
    n = 0;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      if (done) n++;
    end
    check(n == 0 && res_word == keep_r, "R9 frozen", 64'(n), 64'd0);
    @(negedge clk); en = 1'b1;
    wait_done(n);
    check(n > 0 && quot_out == 16'h0200 && rem_out == 16'h0000 && res_word == exp_res(w),
          "R9 resume result", {32'd0, quot_out, rem_out}, {32'd0, 16'h0200, 16'h0000});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule